// File: doc/BRIEF.md
# GPIO bank with function select

A register-mapped controller for a bank of general-purpose pins (54 by default) on a 32-bit word bus. Each pin carries a 3-bit function code. One code turns the pin into a plain output, whose value is held in an output latch. The other codes hand the pin to an external alternate-function mux, which receives every pin's code on a flat select bus. Output latch bits are changed through separate write-one-to-set and write-one-to-clear words, so software never needs a read-modify-write.

Pad levels pass through a two-flop synchroniser. They can be read back, and they feed an event detector. The detector has four independent enable words: rising edge, falling edge, high level and low level. Hits collect in a sticky status word that software clears by writing ones. Two further enable words are stored for asynchronous edge detectors that live outside this block.

Pull resistors are programmed in two steps. First, software stages a pull value in a control word and leaves it alone for a setup interval. Then it raises bits in a pull-clock word. Only pins whose clock bit rises take the staged value. Every other pin keeps its pull state.

Top module: `gpio_bank`

## Requirements
- R1: After reset, all function codes are 000 (input), pad_out, pad_oe, pad_pu, pad_pd and alt_sel are all zero, and every register reads 0.
- R2: Pin n's code lives in the function word at byte offset 4*(n/10), bits (n%10)*3+2 down to (n%10)*3. Bits 31:30 of each function word are ignored on write and read as 0. Codes are: 000 input, 001 output, 100/101/110/111 alternates 0-3, 011 alternate 4, 010 alternate 5. pad_oe[n] is 1 exactly when the code is 001. alt_sel[3n+2:3n] always carries the code.
- R3: Writing to the set words (0x1C for pins 0-31, 0x20 for pins 32-53 at bits 21:0) sets the output latch bit of every pin written with 1, and pad_out shows it from the next cycle. Bits written 0 change nothing. The set words read as 0.
- R4: Writing to the clear words (0x28 and 0x2C, same pin layout) clears the latch bit of every pin written with 1. Bits written 0 change nothing. The clear words read as 0.
- R5: The level words (0x34 and 0x38) return the synchronised pad inputs, which follow pad_in within three cycles.
- R6: With a pin's bit set in the rising-enable word (0x4C/0x50) or the falling-enable word (0x58/0x5C), a synchronised 0-to-1 or 1-to-0 transition sets that pin's bit in the status word (0x40/0x44). Pins without an enabled detector never set status.
- R7: With a pin's bit set in the high-enable word (0x64/0x68) or the low-enable word (0x70/0x74), the status bit is set on every cycle the synchronised level is 1 or 0, respectively.
- R8: Status bits stay set until software writes 1 to them. Writing 0 leaves them unchanged. When a detection and a clear for the same bit happen in the same cycle, the detection wins.
- R9: The asynchronous rising and falling enable words (0x7C/0x80 and 0x88/0x8C) read back what was written and have no effect on the status word.
- R10: The pull-control word at 0x94 holds 2 bits that read back: 0 none, 1 pull-down, 2 pull-up, 3 treated as none. pad_pu and pad_pd are never both 1 for a pin.
- R11: The pull-clock words (0x98/0x9C) read back as written. A pin takes the staged pull value only when its clock bit goes from 0 to 1 on a write that lands at least PULL_SETUP cycles after the last pull-control write. Otherwise, and for all pins whose bit does not rise, pull state is unchanged.
- R12: Reads of unmapped or unaligned addresses (for example 0x18 and 0xA0) return 0 and writes to them change nothing. Bits above the last pin in the upper words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data (0 when no read was requested) |
| pad_in | input | NPINS | Pad input levels, asynchronous |
| pad_out | output | NPINS | Output latch values |
| pad_oe | output | NPINS | Output enable, 1 for pins coded as output |
| pad_pu | output | NPINS | Pull-up enable per pin |
| pad_pd | output | NPINS | Pull-down enable per pin |
| alt_sel | output | 3*NPINS | Function code per pin for the external mux |

## Verification
The hardest case is the pull setup window. A pull-clock write must land exactly PULL_SETUP cycles after the control write to be accepted, and one cycle earlier to be refused. The clock bit must also rise rather than merely be 1. The bench builds this with single-cycle bus writes separated by a counted number of idle cycles, and it tests both sides of the boundary. It also re-writes a clock bit that is already set to confirm nothing latches. A second hard case is the race between a level detection and a write-one-to-clear of the same status bit: the bench holds a pad high with the high detector enabled while clearing. Output latch and function-word behaviour is driven by seeded random set, clear and select writes, checked against a bench model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register byte offsets (software decodes these)
    localparam logic [7:0] OFS_SET_LO  = 8'h1C;
    localparam logic [7:0] OFS_SET_HI  = 8'h20;
    localparam logic [7:0] OFS_CLR_LO  = 8'h28;
    localparam logic [7:0] OFS_CLR_HI  = 8'h2C;
    localparam logic [7:0] OFS_LVL_LO  = 8'h34;
    localparam logic [7:0] OFS_LVL_HI  = 8'h38;
    localparam logic [7:0] OFS_EVT_LO  = 8'h40;
    localparam logic [7:0] OFS_EVT_HI  = 8'h44;
    localparam logic [7:0] OFS_REN_LO  = 8'h4C;
    localparam logic [7:0] OFS_REN_HI  = 8'h50;
    localparam logic [7:0] OFS_FEN_LO  = 8'h58;
    localparam logic [7:0] OFS_FEN_HI  = 8'h5C;
    localparam logic [7:0] OFS_HEN_LO  = 8'h64;
    localparam logic [7:0] OFS_HEN_HI  = 8'h68;
    localparam logic [7:0] OFS_LEN_LO  = 8'h70;
    localparam logic [7:0] OFS_LEN_HI  = 8'h74;
    localparam logic [7:0] OFS_ARE_LO  = 8'h7C;
    localparam logic [7:0] OFS_ARE_HI  = 8'h80;
    localparam logic [7:0] OFS_AFE_LO  = 8'h88;
    localparam logic [7:0] OFS_AFE_HI  = 8'h8C;
    localparam logic [7:0] OFS_PCTL    = 8'h94;
    localparam logic [7:0] OFS_PCLK_LO = 8'h98;
    localparam logic [7:0] OFS_PCLK_HI = 8'h9C;

    localparam int PINS_PER_WORD = 10;
    localparam int CODE_W        = 3;

    typedef enum logic [2:0] {
        FN_INPUT  = 3'b000,
        FN_OUTPUT = 3'b001,
        FN_ALT5   = 3'b010,
        FN_ALT4   = 3'b011,
        FN_ALT0   = 3'b100,
        FN_ALT1   = 3'b101,
        FN_ALT2   = 3'b110,
        FN_ALT3   = 3'b111
    } pin_fn_e;

    typedef enum logic [1:0] {
        PULL_OFF  = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2,
        PULL_RSVD = 2'd3
    } pull_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 54,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            st_d[s] = st_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
    parameter int NPINS = 54
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] en_rise,
    input  logic [NPINS-1:0] en_fall,
    input  logic [NPINS-1:0] en_high,
    input  logic [NPINS-1:0] en_low,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] status
);

    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] stat;
    } ev_t;

    ev_t ev_d, ev_q;
    logic [NPINS-1:0] hit;

    always_comb begin
        hit = (en_rise & level & ~ev_q.prev)
            | (en_fall & ~level & ev_q.prev)
            | (en_high & level)
            | (en_low & ~level);
        ev_d      = ev_q;
        ev_d.prev = level;
        // detection takes priority over a same-cycle clear
        ev_d.stat = (ev_q.stat & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign status = ev_q.stat;

endmodule

// File: rtl/gpio_pull_unit.sv
module gpio_pull_unit
    import gpio_bank_pkg::*;
#(
    parameter int NPINS      = 54,
    parameter int PULL_SETUP = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [1:0]       ctl_wd,
    input  logic             pclk_we_lo,
    input  logic             pclk_we_hi,
    input  logic [31:0]      pclk_wd,
    output logic [1:0]       ctl,
    output logic [NPINS-1:0] pclk,
    output logic [NPINS-1:0] pull_up,
    output logic [NPINS-1:0] pull_dn
);

    localparam int CW = $clog2(PULL_SETUP + 1);

    typedef struct packed {
        logic [1:0]             ctl;
        logic [CW-1:0]          cnt;
        logic [NPINS-1:0]       pclk;
        logic [NPINS-1:0][1:0]  state;
    } pull_t;

    pull_t p_d, p_q;
    logic [63:0]      pclk_wide;
    logic [NPINS-1:0] rising;
    logic             armed;

    always_comb begin
        p_d = p_q;

        pclk_wide               = '0;
        pclk_wide[NPINS-1:0]    = p_q.pclk;
        if (pclk_we_lo) pclk_wide[31:0]  = pclk_wd;
        if (pclk_we_hi) pclk_wide[63:32] = pclk_wd;
        p_d.pclk = pclk_wide[NPINS-1:0];

        rising = p_d.pclk & ~p_q.pclk;
        armed  = (p_q.cnt >= CW'(PULL_SETUP));

        if (armed) begin
            for (int i = 0; i < NPINS; i++) begin
                if (rising[i]) p_d.state[i] = p_q.ctl;
            end
        end

        if (ctl_we) begin
            p_d.ctl = ctl_wd;
            p_d.cnt = CW'(1);
        end else if (p_q.cnt < CW'(PULL_SETUP)) begin
            p_d.cnt = p_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign ctl  = p_q.ctl;
    assign pclk = p_q.pclk;

    for (genvar i = 0; i < NPINS; i++) begin : g_pad
        assign pull_up[i] = (p_q.state[i] == PULL_UP);
        assign pull_dn[i] = (p_q.state[i] == PULL_DOWN);
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 54,
    parameter int PULL_SETUP  = 150,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [7:0]             bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NPINS-1:0]       pad_in,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe,
    output logic [NPINS-1:0]       pad_pu,
    output logic [NPINS-1:0]       pad_pd,
    output logic [3*NPINS-1:0]     alt_sel
);

    localparam int FSEL_WORDS = (NPINS + PINS_PER_WORD - 1) / PINS_PER_WORD;
    localparam int FSEL_BITS  = PINS_PER_WORD * CODE_W;

    typedef struct packed {
        logic [FSEL_WORDS-1:0][FSEL_BITS-1:0] fsel;
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] en_rise;
        logic [NPINS-1:0] en_fall;
        logic [NPINS-1:0] en_high;
        logic [NPINS-1:0] en_low;
        logic [NPINS-1:0] en_arise;
        logic [NPINS-1:0] en_afall;
        logic [31:0]      rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NPINS-1:0] level;
    logic [NPINS-1:0] evt_status;
    logic [NPINS-1:0] evt_clr;
    logic [NPINS-1:0] pclk;
    logic [1:0]       pctl;
    logic [63:0]      set_w, clr_w, evclr_w;
    logic [31:0]      rd_val;

    function automatic logic [31:0] word_of(input logic [NPINS-1:0] v, input logic hi);
        logic [63:0] t;
        t = '0;
        t[NPINS-1:0] = v;
        return hi ? t[63:32] : t[31:0];
    endfunction

    function automatic logic [NPINS-1:0] upd_pair(input logic [NPINS-1:0] cur,
                                                  input logic we_lo, input logic we_hi,
                                                  input logic [31:0] wd);
        logic [63:0] t;
        t = '0;
        t[NPINS-1:0] = cur;
        if (we_lo) t[31:0]  = wd;
        if (we_hi) t[63:32] = wd;
        return t[NPINS-1:0];
    endfunction

    function automatic logic [63:0] strobe(input logic we_lo, input logic we_hi,
                                           input logic [31:0] wd);
        logic [63:0] t;
        t = '0;
        if (we_lo) t[31:0]  = wd;
        if (we_hi) t[63:32] = wd;
        return t;
    endfunction

    // write masks for the write-one registers
    always_comb begin
        set_w   = strobe(bus_wr && bus_addr == OFS_SET_LO, bus_wr && bus_addr == OFS_SET_HI, bus_wdata);
        clr_w   = strobe(bus_wr && bus_addr == OFS_CLR_LO, bus_wr && bus_addr == OFS_CLR_HI, bus_wdata);
        evclr_w = strobe(bus_wr && bus_addr == OFS_EVT_LO, bus_wr && bus_addr == OFS_EVT_HI, bus_wdata);
    end

    assign evt_clr = evclr_w[NPINS-1:0];

    // read mux
    always_comb begin
        rd_val = '0;
        case (bus_addr)
            OFS_LVL_LO:  rd_val = word_of(level, 1'b0);
            OFS_LVL_HI:  rd_val = word_of(level, 1'b1);
            OFS_EVT_LO:  rd_val = word_of(evt_status, 1'b0);
            OFS_EVT_HI:  rd_val = word_of(evt_status, 1'b1);
            OFS_REN_LO:  rd_val = word_of(r_q.en_rise, 1'b0);
            OFS_REN_HI:  rd_val = word_of(r_q.en_rise, 1'b1);
            OFS_FEN_LO:  rd_val = word_of(r_q.en_fall, 1'b0);
            OFS_FEN_HI:  rd_val = word_of(r_q.en_fall, 1'b1);
            OFS_HEN_LO:  rd_val = word_of(r_q.en_high, 1'b0);
            OFS_HEN_HI:  rd_val = word_of(r_q.en_high, 1'b1);
            OFS_LEN_LO:  rd_val = word_of(r_q.en_low, 1'b0);
            OFS_LEN_HI:  rd_val = word_of(r_q.en_low, 1'b1);
            OFS_ARE_LO:  rd_val = word_of(r_q.en_arise, 1'b0);
            OFS_ARE_HI:  rd_val = word_of(r_q.en_arise, 1'b1);
            OFS_AFE_LO:  rd_val = word_of(r_q.en_afall, 1'b0);
            OFS_AFE_HI:  rd_val = word_of(r_q.en_afall, 1'b1);
            OFS_PCTL:    rd_val = {30'd0, pctl};
            OFS_PCLK_LO: rd_val = word_of(pclk, 1'b0);
            OFS_PCLK_HI: rd_val = word_of(pclk, 1'b1);
            default: begin
                for (int w = 0; w < FSEL_WORDS; w++) begin
                    if (bus_addr == 8'(4 * w)) rd_val = {{(32-FSEL_BITS){1'b0}}, r_q.fsel[w]};
                end
            end
        endcase
    end

    // next-state of the register file
    always_comb begin
        r_d = r_q;
        for (int w = 0; w < FSEL_WORDS; w++) begin
            if (bus_wr && bus_addr == 8'(4 * w)) r_d.fsel[w] = bus_wdata[FSEL_BITS-1:0];
        end
        r_d.out      = (r_q.out | set_w[NPINS-1:0]) & ~clr_w[NPINS-1:0];
        r_d.en_rise  = upd_pair(r_q.en_rise,  bus_wr && bus_addr == OFS_REN_LO, bus_wr && bus_addr == OFS_REN_HI, bus_wdata);
        r_d.en_fall  = upd_pair(r_q.en_fall,  bus_wr && bus_addr == OFS_FEN_LO, bus_wr && bus_addr == OFS_FEN_HI, bus_wdata);
        r_d.en_high  = upd_pair(r_q.en_high,  bus_wr && bus_addr == OFS_HEN_LO, bus_wr && bus_addr == OFS_HEN_HI, bus_wdata);
        r_d.en_low   = upd_pair(r_q.en_low,   bus_wr && bus_addr == OFS_LEN_LO, bus_wr && bus_addr == OFS_LEN_HI, bus_wdata);
        r_d.en_arise = upd_pair(r_q.en_arise, bus_wr && bus_addr == OFS_ARE_LO, bus_wr && bus_addr == OFS_ARE_HI, bus_wdata);
        r_d.en_afall = upd_pair(r_q.en_afall, bus_wr && bus_addr == OFS_AFE_LO, bus_wr && bus_addr == OFS_AFE_HI, bus_wdata);
        r_d.rdata    = bus_rd ? rd_val : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    gpio_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (level)
    );

    gpio_event_unit #(
        .NPINS (NPINS)
    ) u_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (level),
        .en_rise (r_q.en_rise),
        .en_fall (r_q.en_fall),
        .en_high (r_q.en_high),
        .en_low  (r_q.en_low),
        .clr     (evt_clr),
        .status  (evt_status)
    );

    gpio_pull_unit #(
        .NPINS      (NPINS),
        .PULL_SETUP (PULL_SETUP)
    ) u_pull (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (bus_wr && bus_addr == OFS_PCTL),
        .ctl_wd     (bus_wdata[1:0]),
        .pclk_we_lo (bus_wr && bus_addr == OFS_PCLK_LO),
        .pclk_we_hi (bus_wr && bus_addr == OFS_PCLK_HI),
        .pclk_wd    (bus_wdata),
        .ctl        (pctl),
        .pclk       (pclk),
        .pull_up    (pad_pu),
        .pull_dn    (pad_pd)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam int WI = i / PINS_PER_WORD;
        localparam int BI = (i % PINS_PER_WORD) * CODE_W;
        assign alt_sel[CODE_W*i +: CODE_W] = r_q.fsel[WI][BI +: CODE_W];
        assign pad_oe[i] = (r_q.fsel[WI][BI +: CODE_W] == FN_OUTPUT);
    end

    assign pad_out   = r_q.out;
    assign bus_rdata = r_q.rdata;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NPINS = 54
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [2:0]       wd_lo,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pu,
    input logic [NPINS-1:0] pad_pd,
    input logic [NPINS-1:0] evt_status,
    input logic [NPINS-1:0] evt_clr
);

    logic pclk_wr;
    assign pclk_wr = bus_wr && (bus_addr == 8'h98 || bus_addr == 8'h9C);

    // R2: code 001 written for pin 0 enables its output driver
    a_r2_out_code_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00 && wd_lo == 3'b001) |=> pad_oe[0]);

    // R2: any other code for pin 0 leaves the driver off
    a_r2_alt_code_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h00 && wd_lo != 3'b001) |=> !pad_oe[0]);

    // R3: a set write drives the pin high next cycle
    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h1C && wd_lo[0]) |=> pad_out[0]);

    // R4: a clear write drives the pin low next cycle
    a_r4_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h28 && wd_lo[0]) |=> !pad_out[0]);

    // R8: status bits not being cleared never drop
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_status & $past(evt_status) & ~$past(evt_clr)) == ($past(evt_status) & ~$past(evt_clr))));

    // R10: never pull up and down at once
    a_r10_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_pd) == '0));

    // R11: pull state only moves after a pull-clock write
    a_r11_pull_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pclk_wr) |-> ($stable(pad_pu) && $stable(pad_pd)));

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wd_lo      (bus_wdata[2:0]),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .pad_pd     (pad_pd),
    .evt_status (evt_status),
    .evt_clr    (evt_clr)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;

    localparam int NP    = 54;
    localparam int SETUP = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic            bus_rd = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   pad_out, pad_oe, pad_pu, pad_pd;
    logic [3*NP-1:0] alt_sel;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [63:0]       m_out;
    logic [5:0][29:0]  m_fsel;

    always #5 clk = ~clk;

    gpio_bank #(.NPINS(NP), .PULL_SETUP(SETUP), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_sel(alt_sel)
    );

    task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all bus tasks start and end on a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NP-1:0] exp_oe(input logic [5:0][29:0] f);
        logic [NP-1:0] v;
        for (int i = 0; i < NP; i++) v[i] = (f[i/10][(i%10)*3 +: 3] == 3'b001);
        return v;
    endfunction

    function automatic logic [3*NP-1:0] exp_alt(input logic [5:0][29:0] f);
        logic [3*NP-1:0] v;
        for (int i = 0; i < NP; i++) v[3*i +: 3] = f[i/10][(i%10)*3 +: 3];
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h0000_5EED));
        m_out  = '0;
        m_fsel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_out", 192'(pad_out), 192'(0));
        chk("R1 pad_oe", 192'(pad_oe), 192'(0));
        chk("R1 pulls", 192'({pad_pu, pad_pd}), 192'(0));
        chk("R1 alt_sel", 192'(alt_sel), 192'(0));
        rd(8'h00, d); chk("R1 fsel0 read", 192'(d), 192'(0));
        rd(8'h94, d); chk("R1 pull ctl read", 192'(d), 192'(0));

        // R2 directed layout: pin 13 output, pin 14 alt0, pin 53 output
        wr(8'h04, 32'hC000_0000 | (32'b001 << 9) | (32'b100 << 12));
        m_fsel[1] = 30'((32'b001 << 9) | (32'b100 << 12));
        chk("R2 oe pin13", 192'(pad_oe[13]), 192'(1));
        chk("R2 oe pin14 off", 192'(pad_oe[14]), 192'(0));
        chk("R2 alt pin14", 192'(alt_sel[42 +: 3]), 192'(3'b100));
        rd(8'h04, d); chk("R2 fsel1 read drops 31:30", 192'(d), 192'(m_fsel[1]));
        wr(8'h14, 32'b001 << 9);
        m_fsel[5] = 30'(32'b001 << 9);
        chk("R2 oe pin53", 192'(pad_oe[53]), 192'(1));

        // R2 R3 R4 random set/clear/select traffic
        for (int it = 0; it < 80; it++) begin
            int op;
            logic [31:0] v;
            op = int'($urandom % 5);
            v  = $urandom;
            case (op)
                0: begin wr(8'h1C, v); m_out[31:0]  = m_out[31:0] | v; end
                1: begin wr(8'h20, v); m_out[63:32] = m_out[63:32] | v; end
                2: begin wr(8'h28, v); m_out[31:0]  = m_out[31:0] & ~v; end
                3: begin wr(8'h2C, v); m_out[63:32] = m_out[63:32] & ~v; end
                default: begin
                    int w;
                    w = int'($urandom % 6);
                    wr(8'(4 * w), v);
                    m_fsel[w] = v[29:0];
                end
            endcase
            chk("R3 R4 random pad_out", 192'(pad_out), 192'(m_out[NP-1:0]));
            chk("R2 random pad_oe", 192'(pad_oe), 192'(exp_oe(m_fsel)));
            chk("R2 random alt_sel", 192'(alt_sel), 192'(exp_alt(m_fsel)));
        end

        // R3 R4 zero writes and read-as-zero
        wr(8'h1C, 32'h0); chk("R3 zero set no effect", 192'(pad_out), 192'(m_out[NP-1:0]));
        wr(8'h2C, 32'h0); chk("R4 zero clear no effect", 192'(pad_out), 192'(m_out[NP-1:0]));
        rd(8'h1C, d); chk("R3 set reads 0", 192'(d), 192'(0));
        rd(8'h2C, d); chk("R4 clear reads 0", 192'(d), 192'(0));

        // R5 R12 level readback
        pad_in = 54'h2A_5A5A_C3C3_F00F;
        idle(3);
        rd(8'h34, d); chk("R5 level lo", 192'(d), 192'(32'hC3C3_F00F));
        rd(8'h38, d); chk("R5 R12 level hi", 192'(d), 192'(32'h002A_5A5A));

        // R6 edge events
        pad_in = '0;
        idle(4);
        wr(8'h4C, 32'h1 << 5);
        wr(8'h5C, 32'h1 << 8);
        pad_in[40] = 1'b1;
        idle(4);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R6 status clean", 192'(d), 192'(0));
        pad_in[5] = 1'b1; pad_in[6] = 1'b1;
        idle(4);
        rd(8'h40, d); chk("R6 rising pin5 only", 192'(d), 192'(32'h1 << 5));
        pad_in[40] = 1'b0;
        idle(4);
        rd(8'h44, d); chk("R6 falling pin40", 192'(d), 192'(32'h1 << 8));

        // R8 sticky and clear
        pad_in[5] = 1'b0;
        idle(4);
        rd(8'h40, d); chk("R8 sticky after release", 192'(d), 192'(32'h1 << 5));
        wr(8'h40, 32'h0);
        rd(8'h40, d); chk("R8 write 0 keeps", 192'(d), 192'(32'h1 << 5));
        wr(8'h40, 32'h1 << 5);
        rd(8'h40, d); chk("R8 write 1 clears", 192'(d), 192'(0));

        // R7 level events, R8 detection beats clear
        wr(8'h64, 32'h1 << 7);
        pad_in[7] = 1'b1;
        idle(4);
        wr(8'h40, 32'h1 << 7);
        rd(8'h40, d); chk("R7 R8 high held survives clear", 192'(d), 192'(32'h1 << 7));
        wr(8'h74, 32'h1 << 1);
        idle(1);
        rd(8'h44, d); chk("R7 low pin33", 192'(d), 192'(32'h1 << 8 | 32'h1 << 1));
        wr(8'h64, 32'h0);
        wr(8'h74, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h40, d); chk("R7 disabled clears lo", 192'(d), 192'(0));

        // R9 async enables are storage only
        wr(8'h7C, 32'h1 << 9);
        wr(8'h8C, 32'h003F_FFFF);
        pad_in[9] = 1'b1;
        idle(4);
        rd(8'h7C, d); chk("R9 async rise read", 192'(d), 192'(32'h1 << 9));
        rd(8'h8C, d); chk("R9 async fall read", 192'(d), 192'(32'h003F_FFFF));
        rd(8'h40, d); chk("R9 no status from async", 192'(d), 192'(0));

        // R10 R11 pull programming
        wr(8'h94, 32'd2);
        idle(SETUP - 1);
        wr(8'h98, 32'h1 << 3);
        chk("R11 pull-up pin3 accepted", 192'(pad_pu), 192'(64'h1 << 3));
        chk("R11 no pull-down", 192'(pad_pd), 192'(0));
        rd(8'h94, d); chk("R10 ctl read", 192'(d), 192'(2));
        rd(8'h98, d); chk("R11 pclk read", 192'(d), 192'(32'h8));
        wr(8'h98, 32'h0);
        wr(8'h94, 32'd1);
        idle(SETUP - 2);
        wr(8'h98, 32'h1 << 3);
        chk("R11 early clock ignored", 192'({pad_pu, pad_pd}), 192'({54'h8, 54'h0}));
        wr(8'h98, 32'h0);
        idle(2);
        wr(8'h98, 32'h1 << 3);
        chk("R11 pull-down pin3", 192'({pad_pu, pad_pd}), 192'({54'h0, 54'h8}));
        wr(8'h94, 32'd2);
        idle(SETUP);
        wr(8'h98, 32'h1 << 3);
        chk("R11 held bit no edge", 192'({pad_pu, pad_pd}), 192'({54'h0, 54'h8}));
        wr(8'h9C, 32'h1 << 18);
        chk("R11 pull-up pin50 others kept", 192'({pad_pu, pad_pd}), 192'({54'h1 << 50, 54'h8}));
        wr(8'h94, 32'd3);
        idle(SETUP);
        wr(8'h9C, 32'h0);
        wr(8'h9C, 32'h1 << 18);
        chk("R10 code 3 is none", 192'({pad_pu, pad_pd}), 192'({54'h0, 54'h8}));

        // R12 unmapped
        rd(8'h18, d); chk("R12 0x18 reads 0", 192'(d), 192'(0));
        rd(8'h1D, d); chk("R12 unaligned reads 0", 192'(d), 192'(0));
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0, d); chk("R12 0xA0 reads 0", 192'(d), 192'(0));
        chk("R12 outputs untouched", 192'({pad_out, pad_oe}), 192'({m_out[NP-1:0], exp_oe(m_fsel)}));

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule